// File: doc/BRIEF.md
# SPI Master Shift Engine with Run/Stop Control

This block is the serial core of an SPI master. Commands arrive on a valid/ready interface. Each command carries up to 16 bits of frame data, a frame length, a chip-select number from 0 to 7 and an end-of-queue marker. The engine turns each accepted command into one serial frame on SCK, SOUT and eight active-low selects. It samples SIN during the frame and returns the received word on a second valid/ready interface.

A two-state controller (STOPPED, RUNNING) decides whether frames may begin. The block starts only when every enabling input agrees. It stops as soon as any stop input is raised, but never in the middle of a frame: a frame already in progress runs to the end, and the controller then drops to STOPPED. Configuration inputs may therefore be changed safely whenever the status output is low. A command that carries the end-of-queue marker raises a sticky flag when its frame finishes. That flag stops the block until software pulses the clear input.

Top module: `spi_runstop_master`

## Requirements
- R1: After reset the block is STOPPED. `running`, `eoq_flag`, `cmd_ready`, `rsp_valid` and `sck` are low, and all of `cs_n` are high.
- R2: The block moves from STOPPED to RUNNING on the next clock edge only when all of these hold: `cfg_mode` is 2'b00, `halt` is low, `eoq_flag` is low, and `dbg_mode` and `frz_en` are not both high.
- R3: While STOPPED, `cmd_ready` stays low and no chip select is asserted.
- R4: When RUNNING with no frame in progress, any stop condition (`halt`, `eoq_flag`, `dbg_mode` with `frz_en`, or `cfg_mode` not 2'b00) moves the block to STOPPED on the next clock edge, and `cmd_ready` drops at once.
- R5: A stop condition raised during a frame does not cut it short. The frame completes, its response is delivered, no further command is accepted, and the block is STOPPED one cycle after the response appears.
- R6: SCK idles low. Each frame sends the low L bits of `cmd_data` MSB first on SOUT, and SOUT changes only on falling SCK edges. L is `cmd_len` limited to the range 4 to 16: lengths below 4 send 4 bits and lengths above 16 send 16 bits.
- R7: SIN is sampled on each rising SCK edge. `rsp_data` holds the L received bits right-aligned, with the first bit received in position L-1 and the upper bits zero.
- R8: Each SCK half-period lasts `clk_div`+1 clock cycles. The select is asserted one half-period before the first rising edge and released one half-period after the last falling edge. From the accepting edge to the edge that raises `rsp_valid` takes exactly (2L+1)·(`clk_div`+1) cycles.
- R9: During a frame only `cs_n[cmd_cs]` is low; at most one select is ever low.
- R10: A command with `cmd_eoq` set raises `eoq_flag` at the end of its frame. The flag stays high until `eoq_clr` is pulsed, and the block restarts after the clear if no other stop condition holds.
- R11: `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen high. No new command is accepted while a response is pending.
- R12: A `cfg_mode` other than 2'b00 keeps the block from starting even when all other enabling conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Operating configuration; 2'b00 selects SPI |
| halt | input | 1 | Stop request |
| frz_en | input | 1 | Freeze enable; combined with debug mode |
| dbg_mode | input | 1 | Device debug mode indicator |
| eoq_clr | input | 1 | Pulse that clears the end-of-queue flag |
| clk_div | input | 8 | SCK divider N; half-period is N+1 clocks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_data | input | 16 | Frame data, right-aligned |
| cmd_len | input | 5 | Frame length in bits (4 to 16) |
| cmd_cs | input | 3 | Chip-select number |
| cmd_eoq | input | 1 | Mark this frame as the last of the queue |
| rsp_valid | output | 1 | Received frame available |
| rsp_ready | input | 1 | Receiver takes the response |
| rsp_data | output | 16 | Received frame, right-aligned |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |
| running | output | 1 | High while in RUNNING |
| eoq_flag | output | 1 | Sticky end-of-queue flag |

## Verification
A frame engine stuck in a wrong phase leaves a select low with SCK idle, or holds `running` high after a stop request. The total-cycle check exposes either fault within one frame length of the stimulus. A miscounted bit counter or divider shows up as a wrong edge count or a wrong accept-to-response cycle count in the very frame where it happens. A controller state that disagrees with its inputs appears at `cmd_ready` and `running` one clock after the input changes, and the directed run/stop cases sample exactly there.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

    localparam int unsigned MIN_FRAME = 4;
    localparam logic [1:0]  CFG_SPI   = 2'b00;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LEAD  = 3'd1,
        PH_HIGH  = 3'd2,
        PH_LOW   = 3'd3,
        PH_TRAIL = 3'd4
    } phase_e;

endpackage

// File: rtl/spi_rs_clkgen.sv
module spi_rs_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cg_regs_t;

    cg_regs_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        tick = en && (r_q.cnt == div);
        if (!en || tick) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/spi_rs_ctrl.sv
module spi_rs_ctrl
    import spi_rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       halt,
    input  logic       frz_en,
    input  logic       dbg_mode,
    input  logic       eoq_clr,
    input  logic       busy,
    input  logic       frame_done,
    input  logic       done_eoq,
    output logic       running,
    output logic       eoq_flag,
    output logic       launch_ok
);

    typedef struct packed {
        run_state_e st;
        logic       eoq;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RST = '{st: ST_STOP, eoq: 1'b0};

    ctrl_regs_t r_q, r_d;
    logic       stop_req;

    always_comb begin
        r_d      = r_q;
        stop_req = r_q.eoq || halt || (dbg_mode && frz_en) || (cfg_mode != CFG_SPI);

        case (r_q.st)
            ST_STOP: begin
                if (!stop_req) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (stop_req && !busy) begin
                    r_d.st = ST_STOP;
                end
            end
            default: r_d.st = ST_STOP;
        endcase

        if (eoq_clr) begin
            r_d.eoq = 1'b0;
        end
        if (frame_done && done_eoq) begin
            r_d.eoq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTRL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign running   = (r_q.st == ST_RUN);
    assign eoq_flag  = r_q.eoq;
    assign launch_ok = running && !stop_req;

endmodule

// File: rtl/spi_rs_shifter.sv
module spi_rs_shifter
    import spi_rs_pkg::*;
#(
    parameter  int unsigned DATA_W = 16,
    parameter  int unsigned CS_N   = 8,
    parameter  int unsigned DIV_W  = 8,
    localparam int unsigned LEN_W  = $clog2(DATA_W + 1),
    localparam int unsigned CS_W   = $clog2(CS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_ok,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic              cmd_eoq,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              tick,
    output logic              tick_en,
    output logic [DIV_W-1:0]  div_o,
    input  logic              sin,
    output logic              sck,
    output logic              sout,
    output logic [CS_N-1:0]   cs_n,
    output logic              busy,
    output logic              frame_done,
    output logic              done_eoq
);

    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rxreg;
        logic [DATA_W-1:0] rsp;
        logic              rspv;
        logic [LEN_W-1:0]  bits;
        logic [CS_W-1:0]   cs;
        logic [DIV_W-1:0]  div;
        logic              eoq;
    } sh_regs_t;

    sh_regs_t          r_q, r_d;
    logic [LEN_W-1:0]  eff_len;
    logic [LEN_W-1:0]  pad;
    logic              accept;

    // length limited into the legal window
    always_comb begin
        if (cmd_len < LEN_MIN) begin
            eff_len = LEN_MIN;
        end else if (cmd_len > LEN_MAX) begin
            eff_len = LEN_MAX;
        end else begin
            eff_len = cmd_len;
        end
        pad = LEN_MAX - eff_len;
    end

    assign busy      = (r_q.phase != PH_IDLE);
    assign cmd_ready = launch_ok && !busy && !r_q.rspv;
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        r_d        = r_q;
        frame_done = 1'b0;

        if (r_q.rspv && rsp_ready) begin
            r_d.rspv = 1'b0;
        end

        case (r_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    r_d.phase = PH_LEAD;
                    r_d.shreg = cmd_data << pad;
                    r_d.rxreg = '0;
                    r_d.bits  = eff_len;
                    r_d.cs    = cmd_cs;
                    r_d.div   = clk_div;
                    r_d.eoq   = cmd_eoq;
                end
            end
            PH_LEAD: begin
                if (tick) begin
                    r_d.phase = PH_HIGH;
                    r_d.rxreg = {r_q.rxreg[DATA_W-2:0], sin};
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    r_d.shreg = {r_q.shreg[DATA_W-2:0], 1'b0};
                    r_d.bits  = r_q.bits - 1'b1;
                    if (r_q.bits == LEN_W'(1)) begin
                        r_d.phase = PH_TRAIL;
                    end else begin
                        r_d.phase = PH_LOW;
                    end
                end
            end
            PH_LOW: begin
                if (tick) begin
                    r_d.phase = PH_HIGH;
                    r_d.rxreg = {r_q.rxreg[DATA_W-2:0], sin};
                end
            end
            PH_TRAIL: begin
                if (tick) begin
                    r_d.phase  = PH_IDLE;
                    r_d.rspv   = 1'b1;
                    r_d.rsp    = r_q.rxreg;
                    frame_done = 1'b1;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_eoq  = r_q.eoq;
    assign rsp_valid = r_q.rspv;
    assign rsp_data  = r_q.rsp;
    assign tick_en   = busy;
    assign div_o     = r_q.div;
    assign sck       = (r_q.phase == PH_HIGH);
    assign sout      = r_q.shreg[DATA_W-1];

    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign cs_n[g] = ~(busy && (r_q.cs == CS_W'(g)));
    end

endmodule

// File: rtl/spi_runstop_master.sv
module spi_runstop_master #(
    parameter  int unsigned DATA_W = 16,
    parameter  int unsigned CS_N   = 8,
    parameter  int unsigned DIV_W  = 8,
    localparam int unsigned LEN_W  = $clog2(DATA_W + 1),
    localparam int unsigned CS_W   = $clog2(CS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              halt,
    input  logic              frz_en,
    input  logic              dbg_mode,
    input  logic              eoq_clr,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic              cmd_eoq,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              sck,
    output logic              sout,
    input  logic              sin,
    output logic [CS_N-1:0]   cs_n,
    output logic              running,
    output logic              eoq_flag
);

    logic             launch_ok;
    logic             busy;
    logic             frame_done;
    logic             done_eoq;
    logic             tick;
    logic             tick_en;
    logic [DIV_W-1:0] div_act;

    spi_rs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .halt       (halt),
        .frz_en     (frz_en),
        .dbg_mode   (dbg_mode),
        .eoq_clr    (eoq_clr),
        .busy       (busy),
        .frame_done (frame_done),
        .done_eoq   (done_eoq),
        .running    (running),
        .eoq_flag   (eoq_flag),
        .launch_ok  (launch_ok)
    );

    spi_rs_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .div   (div_act),
        .tick  (tick)
    );

    spi_rs_shifter #(
        .DATA_W (DATA_W),
        .CS_N   (CS_N),
        .DIV_W  (DIV_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_ok  (launch_ok),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_data   (cmd_data),
        .cmd_len    (cmd_len),
        .cmd_cs     (cmd_cs),
        .cmd_eoq    (cmd_eoq),
        .clk_div    (clk_div),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_data   (rsp_data),
        .tick       (tick),
        .tick_en    (tick_en),
        .div_o      (div_act),
        .sin        (sin),
        .sck        (sck),
        .sout       (sout),
        .cs_n       (cs_n),
        .busy       (busy),
        .frame_done (frame_done),
        .done_eoq   (done_eoq)
    );

endmodule

// File: rtl/spi_rs_checker.sv
module spi_rs_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CS_N   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              halt,
    input logic              frz_en,
    input logic              dbg_mode,
    input logic              eoq_clr,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic              sck,
    input logic              sout,
    input logic [CS_N-1:0]   cs_n,
    input logic              running,
    input logic              eoq_flag
);

    logic enable_ok;
    logic idle_lines;

    assign enable_ok  = (cfg_mode == 2'b00) && !halt && !eoq_flag && !(dbg_mode && frz_en);
    assign idle_lines = (cs_n == {CS_N{1'b1}});

    // R2 and R12: a start needs every enabling condition
    a_r2_start_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !enable_ok) |=> !running);

    // R3: commands are taken only while running and idle
    a_r3_ready_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (running && idle_lines));

    // R4: an idle block stops on the next edge
    a_r4_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (running && idle_lines && !enable_ok) |=> !running);

    // R5: a frame in progress keeps the block running
    a_r5_frame_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !idle_lines) |=> running);

    // R6: SCK idles low outside frames
    a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        idle_lines |-> !sck);

    // R6: SOUT moves only together with a falling SCK inside a frame
    a_r6_sout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_lines && $past(!idle_lines) && !$fell(sck)) |-> $stable(sout));

    // R9: never more than one select low
    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // R10: flag holds until cleared
    a_r10_eoq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eoq_flag && !eoq_clr) |=> eoq_flag);

    // R11: response held until taken
    a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

bind spi_runstop_master spi_rs_checker #(
    .DATA_W (DATA_W),
    .CS_N   (CS_N)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .halt      (halt),
    .frz_en    (frz_en),
    .dbg_mode  (dbg_mode),
    .eoq_clr   (eoq_clr),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .sck       (sck),
    .sout      (sout),
    .cs_n      (cs_n),
    .running   (running),
    .eoq_flag  (eoq_flag)
);

// File: tb/tb_spi_runstop_master.sv
module tb_spi_runstop_master;

    typedef struct packed {
        logic [15:0] data;
        logic [4:0]  len;
        logic [2:0]  cs;
        logic [7:0]  div;
        logic [15:0] reply;
        logic [4:0]  elen;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'hA5C3, 5'd16, 3'd0, 8'd0, 16'h3C5A, 5'd16},
        '{16'h000B, 5'd4,  3'd7, 8'd1, 16'h0006, 5'd4 },
        '{16'h0123, 5'd9,  3'd3, 8'd2, 16'h01A5, 5'd9 },
        '{16'h7FFF, 5'd15, 3'd5, 8'd0, 16'h4001, 5'd15},
        '{16'h00F0, 5'd8,  3'd1, 8'd3, 16'h00C3, 5'd8 },
        '{16'hFFFF, 5'd5,  3'd6, 8'd0, 16'h0011, 5'd5 },
        '{16'h000A, 5'd2,  3'd2, 8'd0, 16'h0009, 5'd4 },
        '{16'hBEEF, 5'd20, 3'd4, 8'd1, 16'h1234, 5'd16}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        halt = 1'b1;
    logic        frz_en = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        eoq_clr = 1'b0;
    logic [7:0]  clk_div = 8'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_data = '0;
    logic [4:0]  cmd_len = 5'd8;
    logic [2:0]  cmd_cs = '0;
    logic        cmd_eoq = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [15:0] rsp_data;
    logic        sck;
    logic        sout;
    logic        sin;
    logic [7:0]  cs_n;
    logic        running;
    logic        eoq_flag;

    spi_runstop_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .halt      (halt),
        .frz_en    (frz_en),
        .dbg_mode  (dbg_mode),
        .eoq_clr   (eoq_clr),
        .clk_div   (clk_div),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_data  (cmd_data),
        .cmd_len   (cmd_len),
        .cmd_cs    (cmd_cs),
        .cmd_eoq   (cmd_eoq),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .sck       (sck),
        .sout      (sout),
        .sin       (sin),
        .cs_n      (cs_n),
        .running   (running),
        .eoq_flag  (eoq_flag)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // serial slave model and SCK monitor
    int          frame_id = 0;
    logic [7:0]  exp_csn = 8'hFF;
    logic [15:0] slv = '0;
    int          mon_id = -1;
    int          fall_id = -1;
    logic [15:0] mon = '0;
    int          mon_n = 0;
    int          cs_bad = 0;
    int          fall_n = 0;
    logic [15:0] slv_sh;

    always @(posedge sck) begin
        if (mon_id != frame_id) begin
            mon    <= {15'b0, sout};
            mon_n  <= 1;
            cs_bad <= (cs_n !== exp_csn) ? 1 : 0;
            mon_id <= frame_id;
        end else begin
            mon    <= {mon[14:0], sout};
            mon_n  <= mon_n + 1;
            if (cs_n !== exp_csn) cs_bad <= cs_bad + 1;
        end
    end

    always @(negedge sck) begin
        if (fall_id != frame_id) begin
            fall_n  <= 1;
            fall_id <= frame_id;
        end else begin
            fall_n <= fall_n + 1;
        end
    end

    assign slv_sh = slv << ((fall_id == frame_id) ? fall_n : 0);
    assign sin    = slv_sh[15];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // offer a command and wait for its acceptance; returns cycle stamp
    task automatic issue(input vec_t v, input bit eoq, output int t0);
        exp_csn = ~(8'b1 << v.cs);
        slv     = v.reply << (16 - v.elen);
        frame_id++;
        @(negedge clk);
        cmd_data  = v.data;
        cmd_len   = v.len;
        cmd_cs    = v.cs;
        cmd_eoq   = eoq;
        clk_div   = v.div;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        t0 = cyc;
    endtask

    task automatic wait_rsp(output int t1);
        while (!rsp_valid) @(negedge clk);
        t1 = cyc;
    endtask

    task automatic take_rsp();
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic check_frame(input vec_t v, input int t0, input int t1);
        int mask;
        mask = (1 << v.elen) - 1;
        chk(rsp_data == v.reply, "R7", "rx word", rsp_data, v.reply);
        chk(mon == (v.data & mask), "R6", "tx bits msb first", mon, v.data & mask);
        chk(mon_n == v.elen, "R6", "rising edge count", mon_n, v.elen);
        chk(cs_bad == 0, "R9", "select pattern at edges", cs_bad, 0);
        chk((t1 - t0) == (2 * v.elen + 1) * (v.div + 1), "R8", "frame cycles",
            t1 - t0, (2 * v.elen + 1) * (v.div + 1));
        chk(cs_n == 8'hFF && sck == 1'b0, "R8", "lines idle after frame",
            {cs_n, 7'b0, sck}, 16'hFF00);
    endtask

    initial begin
        int t0;
        int t1;
        logic [15:0] held;

        // R1: reset state
        tick_n(3);
        chk(running == 1'b0, "R1", "running in reset", running, 0);
        chk(cs_n == 8'hFF, "R1", "selects in reset", cs_n, 8'hFF);
        chk(sck == 1'b0 && eoq_flag == 1'b0, "R1", "sck/eoq in reset", {sck, eoq_flag}, 0);
        chk(cmd_ready == 1'b0 && rsp_valid == 1'b0, "R1", "handshakes in reset",
            {cmd_ready, rsp_valid}, 0);
        rst_n = 1'b1;

        // R3: halted, a pending command is refused
        cmd_valid = 1'b1;
        tick_n(4);
        chk(running == 1'b0, "R2", "halt keeps stopped", running, 0);
        chk(cmd_ready == 1'b0 && cs_n == 8'hFF, "R3", "no frame while stopped",
            {cmd_ready, cs_n}, 8'hFF);
        cmd_valid = 1'b0;

        // R12: non-SPI mode blocks start
        cfg_mode = 2'b01;
        halt = 1'b0;
        tick_n(4);
        chk(running == 1'b0, "R12", "mode 01 blocks start", running, 0);
        cfg_mode = 2'b00;
        dbg_mode = 1'b1;
        tick_n(1);
        chk(running == 1'b1, "R2", "debug without freeze starts", running, 1);

        // R4: freeze in debug stops an idle block next edge
        frz_en = 1'b1;
        #0;
        chk(cmd_ready == 1'b0, "R4", "ready drops with stop input", cmd_ready, 0);
        tick_n(1);
        chk(running == 1'b0, "R4", "idle stop next edge", running, 0);
        frz_en = 1'b0;
        dbg_mode = 1'b0;
        tick_n(1);
        chk(running == 1'b1, "R2", "restart after freeze", running, 1);

        // R6 R7 R8 R9: vector table
        for (int k = 0; k < NVEC; k++) begin
            issue(VECS[k], 1'b0, t0);
            wait_rsp(t1);
            check_frame(VECS[k], t0, t1);
            take_rsp();
            chk(rsp_valid == 1'b0, "R11", "response consumed", rsp_valid, 0);
        end

        // R11: response held, new command refused
        issue(VECS[4], 1'b0, t0);
        wait_rsp(t1);
        held = rsp_data;
        cmd_data  = 16'h0055;
        cmd_len   = 5'd8;
        cmd_cs    = 3'd2;
        cmd_valid = 1'b1;
        tick_n(8);
        chk(rsp_valid == 1'b1 && rsp_data == held, "R11", "response held",
            rsp_data, held);
        chk(cmd_ready == 1'b0 && cs_n == 8'hFF, "R11", "no accept while pending",
            {cmd_ready, cs_n}, 8'hFF);
        cmd_valid = 1'b0;
        take_rsp();

        // R5: halt raised mid-frame
        issue(VECS[4], 1'b0, t0);
        tick_n(10);
        halt = 1'b1;
        tick_n(1);
        chk(running == 1'b1 && cs_n != 8'hFF, "R5", "frame continues after halt",
            {running, cs_n}, 0);
        wait_rsp(t1);
        check_frame(VECS[4], t0, t1);
        chk(running == 1'b1 && cmd_ready == 1'b0, "R5", "running, no ready at end",
            {running, cmd_ready}, 2);
        tick_n(1);
        chk(running == 1'b0, "R5", "stopped after frame", running, 0);
        take_rsp();
        halt = 1'b0;
        tick_n(1);
        chk(running == 1'b1, "R2", "restart after halt", running, 1);

        // R10: end-of-queue flag
        issue(VECS[1], 1'b1, t0);
        wait_rsp(t1);
        chk(eoq_flag == 1'b1, "R10", "flag set at frame end", eoq_flag, 1);
        tick_n(1);
        chk(running == 1'b0, "R10", "flag stops block", running, 0);
        take_rsp();
        tick_n(5);
        chk(eoq_flag == 1'b1 && running == 1'b0, "R10", "flag sticky",
            {eoq_flag, running}, 2);
        eoq_clr = 1'b1;
        tick_n(1);
        eoq_clr = 1'b0;
        chk(eoq_flag == 1'b0, "R10", "flag cleared", eoq_flag, 0);
        tick_n(1);
        chk(running == 1'b1, "R10", "restart after clear", running, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule